// File: doc/BRIEF.md
# Ordered Three-Step Dial Lock

This block is a small finite state machine that opens a lock only after three dial operations arrive in one fixed order. Each operation carries a turning direction and a dial position in the range 0 to 39. It enters through a valid/ready stream port, and an operation counts only on a clock edge where both valid and ready are high. The combination is set by parameters: turn right to 13, then left to 22, then right to 3. The same three values in any other order leave the lock closed.

The lock moves through four states held in two bits: idle, first step done, second step done, and open. The state changes only on an accepted operation, a relock request or a reset, and never just because the clock ticks. The open indication is a register. Once the lock is open it refuses further dial operations by holding ready low, and it stays open until relock is asserted.

Back-pressure rules: `op_ready` is high in the three closed states and low in the open state. A producer keeps its operation on the port until it sees ready. An operation offered while ready is low is dropped and has no effect. The block never stalls in a closed state.

Top module: `seq_dial_lock`

## Requirements
- R1: When `rst` is high at a rising clock edge, the next state is idle, whatever `op_valid` and `relock` are doing, and `unlocked` is 0.
- R2: `lock_state` uses the encoding idle=00, first step done=01, second step done=10, open=11. In a cycle with no accepted operation, no relock and no reset, the state holds, so gaps between steps are allowed.
- R3: A step matches when direction (`op_dir`: 1 = right, 0 = left) and `op_num` equal the expected values. In order the steps are right 13, left 22, right 3. Each accepted matching step moves the state up by one on the edge where it is accepted.
- R4: In idle, first step done or second step done, an accepted operation that does not match the next expected step sends the state to idle. If that operation matches the first step, the state goes to first step done instead.
- R5: The three combination values, or one of them repeated, offered in any order other than the required one do not reach the open state.
- R6: An `op_num` above 39 never matches any step. Accepting it in a closed state therefore returns the state to idle.
- R7: `unlocked` is 1 exactly when `lock_state` is open. It is a register and changes on the same edge as the state.
- R8: `op_ready` is 0 in the open state and 1 in the other three states. An operation offered while the lock is open is ignored, and the lock stays open.
- R9: `relock` high at an edge sends the state to idle from any state. It takes priority over an operation accepted in the same cycle, and `rst` takes priority over `relock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A dial operation is offered |
| op_ready | output | 1 | Operation can be accepted (low while open) |
| op_dir | input | 1 | Direction: 1 right, 0 left |
| op_num | input | 6 | Dial position |
| relock | input | 1 | Close the lock and return to idle |
| lock_state | output | 2 | Current state code |
| unlocked | output | 1 | Registered open indication |

## Verification
Two functions can fall in the same cycle: an accepted dial operation and a relock request. Reset can also coincide with both. The bench drives relock together with an operation that would otherwise advance the state, both from idle and from the second step. It also drives reset together with relock and a valid operation. It judges each case by a following state of idle, with `unlocked` low and `op_ready` high. A reference model built from the priority order predicts every cycle, and a scoreboard compares that prediction with the outputs on each edge.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_OPEN = 2'b11
  } lock_state_e;

  localparam int unsigned N_STEPS = 3;
  localparam int unsigned NUM_W   = 6;
  localparam int unsigned ST_W    = 2;
endpackage

// File: rtl/dial_step_cmp.sv
module dial_step_cmp #(
  parameter int unsigned NUM_W    = 6,
  parameter int unsigned N_STEPS  = 3,
  parameter int unsigned DIAL_MAX = 39,
  parameter logic [N_STEPS-1:0]       STEP_DIRS = 3'b101,
  parameter logic [N_STEPS*NUM_W-1:0] STEP_NUMS = {6'd3, 6'd22, 6'd13}
) (
  input  logic             dir_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [N_STEPS-1:0] hit_o
);
  localparam logic [NUM_W-1:0] MAX_V = NUM_W'(DIAL_MAX);

  logic in_range;
  assign in_range = (num_i <= MAX_V);

  for (genvar k = 0; k < N_STEPS; k++) begin : g_step
    logic [NUM_W-1:0] want_num;
    assign want_num = STEP_NUMS[k*NUM_W +: NUM_W];
    assign hit_o[k] = in_range && (dir_i == STEP_DIRS[k]) && (num_i == want_num);
  end
endmodule

// File: rtl/lock_next_logic.sv
module lock_next_logic
  import dial_lock_pkg::*;
(
  input  lock_state_e        cur_i,
  input  logic               accept_i,
  input  logic               relock_i,
  input  logic [N_STEPS-1:0] hit_i,
  output lock_state_e        nxt_o
);
  lock_state_e restart;
  assign restart = hit_i[0] ? ST_ONE : ST_IDLE;

  always_comb begin
    nxt_o = cur_i;
    if (relock_i) begin
      nxt_o = ST_IDLE;
    end else if (accept_i) begin
      unique case (cur_i)
        ST_IDLE: nxt_o = restart;
        ST_ONE:  nxt_o = hit_i[1] ? ST_TWO  : restart;
        ST_TWO:  nxt_o = hit_i[2] ? ST_OPEN : restart;
        ST_OPEN: nxt_o = ST_OPEN;
        default: nxt_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
  import dial_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_e nxt_i,
  output lock_state_e cur_o,
  output logic        open_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o  <= ST_IDLE;
      open_o <= 1'b0;
    end else begin
      cur_o  <= nxt_i;
      open_o <= (nxt_i == ST_OPEN);
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (cur_o == ST_IDLE && !open_o))
    else $error("reset did not force idle");
endmodule

// File: rtl/seq_dial_lock.sv
module seq_dial_lock
  import dial_lock_pkg::*;
#(
  parameter int unsigned DIAL_MAX = 39,
  parameter logic [N_STEPS-1:0]       STEP_DIRS = 3'b101,
  parameter logic [N_STEPS*NUM_W-1:0] STEP_NUMS = {6'd3, 6'd22, 6'd13}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_dir,
  input  logic [NUM_W-1:0] op_num,
  input  logic             relock,
  output logic [ST_W-1:0]  lock_state,
  output logic             unlocked
);
  lock_state_e        cur, nxt;
  logic [N_STEPS-1:0] hit;
  logic               accept;

  assign op_ready   = (cur != ST_OPEN);
  assign accept     = op_valid && op_ready;
  assign lock_state = cur;

  dial_step_cmp #(
    .NUM_W(NUM_W), .N_STEPS(N_STEPS), .DIAL_MAX(DIAL_MAX),
    .STEP_DIRS(STEP_DIRS), .STEP_NUMS(STEP_NUMS)
  ) cmp_i (
    .dir_i(op_dir), .num_i(op_num), .hit_o(hit)
  );

  lock_next_logic nxt_i (
    .cur_i(cur), .accept_i(accept), .relock_i(relock), .hit_i(hit), .nxt_o(nxt)
  );

  lock_state_reg reg_i (
    .clk(clk), .rst(rst), .nxt_i(nxt), .cur_o(cur), .open_o(unlocked)
  );

  // R7
  open_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked == (lock_state == 2'b11)) else $error("unlocked disagrees with state");

  // R9
  relock_idle_chk: assert property (@(posedge clk) disable iff (rst)
    relock |=> (lock_state == 2'b00)) else $error("relock did not return to idle");

  // R8
  open_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !relock) |=> unlocked) else $error("open state left without relock");

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !relock) |=> $stable(lock_state)) else $error("state moved with no event");

  // R3
  final_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_TWO && accept && hit[2] && !relock) |=> unlocked)
    else $error("final step did not open");

  // R4
  mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_ONE && accept && !hit[1] && !hit[0] && !relock) |=> (lock_state == 2'b00))
    else $error("mismatch did not restart");
endmodule

// File: tb/seq_dial_lock_tb_top.sv
`timescale 1ns/1ps
module seq_dial_lock_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       op_dir = 1'b0;
  logic [5:0] op_num = '0;
  logic       relock = 1'b0;
  logic       op_ready;
  logic [1:0] lock_state;
  logic       unlocked;

  typedef struct {
    logic [1:0] st;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         n_checks = 0;
  int         n_fail = 0;
  logic [1:0] model_st = 2'b00;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  seq_dial_lock dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_dir(op_dir), .op_num(op_num), .relock(relock),
    .lock_state(lock_state), .unlocked(unlocked)
  );

  function automatic bit step_hit(int k, bit d, int n);
    case (k)
      0: return (d == 1'b1) && (n == 13);
      1: return (d == 1'b0) && (n == 22);
      2: return (d == 1'b1) && (n == 3);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] model(logic [1:0] s, bit v, bit d, int n, bit rl, bit rs);
    if (rs) return 2'b00;
    if (rl) return 2'b00;
    if (!v || s == 2'b11) return s;
    if (step_hit(int'(s), d, n)) return s + 2'b01;
    return step_hit(0, d, n) ? 2'b01 : 2'b00;
  endfunction

  task automatic drive(bit v, bit d, int n, bit rl, bit rs, string tag);
    exp_t e;
    @(negedge clk);
    op_valid = v; op_dir = d; op_num = 6'(n); relock = rl; rst = rs;
    model_st = model(model_st, v, d, n, rl, rs);
    e.st = model_st; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(string tag);
    drive(1'b0, 1'b0, 0, 1'b0, 1'b0, tag);
  endtask

  task automatic combo(string tag);
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, tag);
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, tag);
    drive(1'b1, 1'b1, 3,  1'b0, 1'b0, tag);
  endtask

  // monitor: compare every edge's result against the queued prediction
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      logic er, eu;
      e  = sb_q.pop_front();
      eu = (e.st == 2'b11);
      er = (e.st != 2'b11);
      n_checks++;
      if (lock_state !== e.st || unlocked !== eu || op_ready !== er) begin
        n_fail++;
        $display("FAIL %s: state=%b unlocked=%b ready=%b, expected state=%b unlocked=%b ready=%b",
                 e.tag, lock_state, unlocked, op_ready, e.st, eu, er);
      end
    end
  end

  initial begin
    // R1: reset wins over a matching op and relock
    drive(1'b1, 1'b1, 13, 1'b1, 1'b1, "R1");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b1, "R1");
    // R2: idle cycles hold state
    idle("R2"); idle("R2");
    // R3 and R7: the correct sequence with gaps
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R3");
    idle("R2");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R3");
    idle("R2");
    drive(1'b1, 1'b1, 3, 1'b0, 1'b0, "R7");
    // R8: ops ignored while open
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R8");
    drive(1'b1, 1'b0, 5, 1'b0, 1'b0, "R8");
    idle("R8");
    // R9: relock from open
    drive(1'b0, 1'b0, 0, 1'b1, 1'b0, "R9");
    // R5: wrong orders
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R5");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R5");
    drive(1'b1, 1'b1, 3,  1'b0, 1'b0, "R5");
    drive(1'b1, 1'b1, 3,  1'b0, 1'b0, "R5");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R5");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R5");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R5");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R5");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R5");
    // R4: wrong direction, restart on first step
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 22, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 4, 1'b0, 1'b0, "R4");
    // R6: out-of-range values
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b1, 43, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b1, 53, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b1, 63, 1'b0, 1'b0, "R6");
    // R9: relock together with a matching op
    drive(1'b1, 1'b1, 13, 1'b1, 1'b0, "R9");
    drive(1'b1, 1'b1, 13, 1'b0, 1'b0, "R9");
    drive(1'b1, 1'b0, 22, 1'b0, 1'b0, "R9");
    drive(1'b1, 1'b1, 3, 1'b1, 1'b0, "R9");
    // R3 again, then reset out of open
    combo("R3");
    idle("R7");
    drive(1'b0, 1'b0, 0, 1'b0, 1'b1, "R1");
    idle("R2");
    idle("R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule